// File: doc/BRIEF.md
# Dual-Halfword Receive Buffer Bus Reader

This block sits between a serial word receiver and a 16-bit host data bus. A one-cycle load strobe from the receiver side captures a complete received word, its parity status and its word format (25-bit or 32-bit) into a holding register, and raises a data-ready flag. The host then pulls the word out as two halfwords. It sets a select line to choose a halfword and pulses a read enable. The registered bus output is driven, with a separate drive-enable, only while that enable is active.

The way fields are placed in the two halfwords depends on the format captured with the word. The first halfword always carries the 8-bit label in its low byte and the parity status in bit 8. Halfwords may be read in any order and any number of times until the next load. A read pulse during which the second halfword was selected clears the data-ready flag when the pulse ends.

Word bit n (n = 1 for the first label bit) is held at index n-1 of the load word.

Top module: `hwr_bus_reader`

## Requirements
- R1: After reset, `data_ready` is 0, `bus_oe` is 0 and `bus_data` is 0.
- R2: A cycle with `ld_strobe` high captures `ld_word`, `ld_parity` and `ld_fmt32`, and `data_ready` reads 1 from the following cycle.
- R3: `bus_oe` equals `rd_en` delayed by one clock. In any cycle where `bus_oe` is 0, `bus_data` is all zeros.
- R4: With `hw_sel` = 0, the driven halfword holds label bits `word[7:0]` in bits 7..0 and the stored parity status in bit 8 (0 = odd, 1 = even).
- R5: In 25-bit format (`ld_fmt32` = 0), bits 15..9 of the first halfword are 0, and the second halfword (`hw_sel` = 1) equals `word[23:8]`: MSB word bit 24 in bit 15 and LSB word bit 9 in bit 0.
- R6: In 32-bit format (`ld_fmt32` = 1), the second halfword equals `word[28:13]`: sign in bit 15, data MSB in bit 14, word bits 27..14 in bits 13..0. The first halfword holds `word[30:29]` in bits 15..14 and `word[12:8]` in bits 13..9.
- R7: Either halfword may be read first and repeatedly. The returned values do not change between loads.
- R8: `data_ready` clears in the cycle after `rd_en` falls, if `hw_sel` was 1 in any cycle of that pulse. A pulse that only read the first halfword leaves it set.
- R9: If a load arrives in the same cycle that a clear would take effect, `data_ready` stays 1 and the new word is held.
- R10: A load overwrites an unread word. Later reads return only the newest word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_strobe | input | 1 | One-cycle load of the holding register |
| ld_word | input | 32 | Received word, word bit n at index n-1 |
| ld_parity | input | 1 | Parity status of the word (0 odd, 1 even) |
| ld_fmt32 | input | 1 | Format of the word: 1 = 32-bit, 0 = 25-bit |
| hw_sel | input | 1 | Halfword select: 0 first, 1 second |
| rd_en | input | 1 | Host read enable |
| bus_data | output | 16 | Registered halfword, zero when not driven |
| bus_oe | output | 1 | Bus drive-enable |
| data_ready | output | 1 | A loaded word has not yet had its second halfword read |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 16-bit bus and an 8-bit label. These are the only values for which both format mappings are fully defined, so every field boundary is reached. Words with alternating and walking patterns are loaded in both formats and with both parity values, so each field position is checked. Multi-cycle read pulses, reads in reverse order, reads of only the first halfword, a load that overwrites an unread word, and a load that coincides with the end of a second-halfword pulse bring every case of the ready flag within reach.

// File: rtl/hwr_pkg.sv
package hwr_pkg;
  localparam int HWR_WORD_W  = 32;
  localparam int HWR_HW_W    = 16;
  localparam int HWR_LABEL_W = 8;

  typedef enum logic { HW_FIRST = 1'b0, HW_SECOND = 1'b1 } hw_sel_e;
  typedef enum logic { FMT_25 = 1'b0, FMT_32 = 1'b1 } word_fmt_e;
endpackage

// File: rtl/hwr_hold_reg.sv
module hwr_hold_reg #(
  parameter int WORD_W = hwr_pkg::HWR_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [WORD_W-1:0] ld_word,
  input  logic              ld_par,
  input  logic              ld_fmt,
  output logic [WORD_W-1:0] word_q,
  output logic              par_q,
  output logic              fmt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      par_q  <= 1'b0;
      fmt_q  <= 1'b0;
    end else if (ld) begin
      word_q <= ld_word;
      par_q  <= ld_par;
      fmt_q  <= ld_fmt;
    end
  end

  // R7: contents are frozen between loads
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
    !ld |=> ($stable(word_q) && $stable(par_q) && $stable(fmt_q)));
  // R2: a load captures its inputs
  p_load_capture_r2: assert property (@(posedge clk) disable iff (rst)
    ld |=> (word_q == $past(ld_word) && par_q == $past(ld_par)));
endmodule

// File: rtl/hwr_hw_format.sv
module hwr_hw_format #(
  parameter int WORD_W  = hwr_pkg::HWR_WORD_W,
  parameter int HW_W    = hwr_pkg::HWR_HW_W,
  parameter int LABEL_W = hwr_pkg::HWR_LABEL_W
) (
  input  logic [WORD_W-1:0] word,
  input  logic              par,
  input  logic              fmt32,
  input  logic              sel,
  output logic [HW_W-1:0]   hw
);
  localparam int FILL_W  = HW_W - LABEL_W - 1;
  localparam int TOP_W   = 2;
  localparam int MID_W   = FILL_W - TOP_W;
  localparam int HI32_LO = WORD_W - 4 - HW_W + 1;

  logic [FILL_W-1:0] fill;
  logic [HW_W-1:0]   first_hw;
  logic [HW_W-1:0]   second_hw;

  always_comb begin
    if (fmt32 == hwr_pkg::FMT_32)
      fill = {word[WORD_W-2 -: TOP_W], word[LABEL_W +: MID_W]};
    else
      fill = '0;
    first_hw = {fill, par, word[LABEL_W-1:0]};
  end

  always_comb begin
    if (fmt32 == hwr_pkg::FMT_32)
      second_hw = word[HI32_LO +: HW_W];
    else
      second_hw = word[LABEL_W +: HW_W];
  end

  assign hw = (sel == hwr_pkg::HW_SECOND) ? second_hw : first_hw;
endmodule

// File: rtl/hwr_ready_ctl.sv
module hwr_ready_ctl (
  input  logic clk,
  input  logic rst,
  input  logic ld,
  input  logic rd_en,
  input  logic sel,
  output logic ready
);
  logic rd_q;
  logic seen_second;
  logic clr;

  assign clr = rd_q && !rd_en && seen_second;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q        <= 1'b0;
      seen_second <= 1'b0;
      ready       <= 1'b0;
    end else begin
      rd_q        <= rd_en;
      seen_second <= rd_en ? (seen_second | sel) : 1'b0;
      if (ld)
        ready <= 1'b1;
      else if (clr)
        ready <= 1'b0;
    end
  end

  // R2: load sets the flag
  p_load_sets_ready_r2: assert property (@(posedge clk) disable iff (rst)
    ld |=> ready);
  // R8: a pulse ending after a second-halfword read clears the flag
  p_second_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (!ld && !rd_en && rd_q && seen_second) |=> !ready);
  // R8: with no load and no ending pulse, the flag holds
  p_ready_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (!ld && !(rd_q && !rd_en)) |=> $stable(ready));
  // R9: load wins over a simultaneous clear
  p_load_beats_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (ld && rd_q && !rd_en) |=> ready);
endmodule

// File: rtl/hwr_bus_reader.sv
module hwr_bus_reader #(
  parameter int WORD_W  = hwr_pkg::HWR_WORD_W,
  parameter int HW_W    = hwr_pkg::HWR_HW_W,
  parameter int LABEL_W = hwr_pkg::HWR_LABEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_strobe,
  input  logic [WORD_W-1:0] ld_word,
  input  logic              ld_parity,
  input  logic              ld_fmt32,
  input  logic              hw_sel,
  input  logic              rd_en,
  output logic [HW_W-1:0]   bus_data,
  output logic              bus_oe,
  output logic              data_ready
);
  logic [WORD_W-1:0] word_q;
  logic              par_q;
  logic              fmt_q;
  logic [HW_W-1:0]   hw_sel_data;

  hwr_hold_reg #(.WORD_W(WORD_W)) u_hold (
    .clk(clk), .rst(rst), .ld(ld_strobe), .ld_word(ld_word),
    .ld_par(ld_parity), .ld_fmt(ld_fmt32),
    .word_q(word_q), .par_q(par_q), .fmt_q(fmt_q)
  );

  hwr_hw_format #(.WORD_W(WORD_W), .HW_W(HW_W), .LABEL_W(LABEL_W)) u_fmt (
    .word(word_q), .par(par_q), .fmt32(fmt_q), .sel(hw_sel), .hw(hw_sel_data)
  );

  hwr_ready_ctl u_rdy (
    .clk(clk), .rst(rst), .ld(ld_strobe), .rd_en(rd_en), .sel(hw_sel),
    .ready(data_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_oe   <= 1'b0;
      bus_data <= '0;
    end else begin
      bus_oe   <= rd_en;
      bus_data <= rd_en ? hw_sel_data : '0;
    end
  end

  // R3: drive-enable follows the read enable by one cycle
  p_oe_follows_r3: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> bus_oe);
  // R3: an undriven bus carries zeros
  p_idle_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (!bus_oe && bus_data == '0));
  // R4: parity status sits in bit 8 of the first halfword
  p_parity_bit_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !hw_sel && !ld_strobe) |=> (bus_data[LABEL_W] == par_q));
  // R4: label byte comes from the low word bits
  p_label_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !hw_sel && !ld_strobe) |=> (bus_data[LABEL_W-1:0] == word_q[LABEL_W-1:0]));
endmodule

// File: tb/test_hwr_bus_reader.sv
module test_hwr_bus_reader;
  logic        clk = 1'b0;
  logic        rst;
  logic        ld_strobe, ld_parity, ld_fmt32, hw_sel, rd_en;
  logic [31:0] ld_word;
  logic [15:0] bus_data;
  logic        bus_oe, data_ready;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  logic [31:0] m_word;
  logic        m_par, m_fmt;

  always #2 clk = ~clk;

  hwr_bus_reader i_hwr_bus_reader (
    .clk(clk), .rst(rst), .ld_strobe(ld_strobe), .ld_word(ld_word),
    .ld_parity(ld_parity), .ld_fmt32(ld_fmt32), .hw_sel(hw_sel), .rd_en(rd_en),
    .bus_data(bus_data), .bus_oe(bus_oe), .data_ready(data_ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_hw(input logic sel);
    if (!sel) begin
      if (m_fmt) return {m_word[30:29], m_word[12:8], m_par, m_word[7:0]}; // R6 R4
      else       return {7'b0, m_par, m_word[7:0]};                       // R5 R4
    end else begin
      if (m_fmt) return m_word[28:13];                                      // R6
      else       return m_word[23:8];                                       // R5
    end
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_oe) begin
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R3: actual oe=1 data %h expected no drive", bus_data);
        end else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, {16'h0, bus_data}, {16'h0, e});
        end
      end else if (bus_data !== 16'h0) begin
        check("R3 idle zero", {16'h0, bus_data}, 32'h0);
      end
    end
  end

  task automatic load(input logic [31:0] w, input logic p, input logic f);
    @(negedge clk);
    ld_strobe = 1'b1; ld_word = w; ld_parity = p; ld_fmt32 = f;
    m_word = w; m_par = p; m_fmt = f;
    @(negedge clk);
    ld_strobe = 1'b0;
  endtask

  task automatic rd_pulse(input logic sel, input int len, input string tag);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rd_en = 1'b1; hw_sel = sel;
      exp_q.push_back(model_hw(sel));
      tag_q.push_back(tag);
    end
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; ld_strobe = 0; ld_word = 0; ld_parity = 0; ld_fmt32 = 0;
    hw_sel = 0; rd_en = 0;
    m_word = 0; m_par = 0; m_fmt = 0;
    repeat (3) @(negedge clk);
    check("R1 ready", {31'h0, data_ready}, 32'h0);
    check("R1 oe", {31'h0, bus_oe}, 32'h0);
    check("R1 data", {16'h0, bus_data}, 32'h0);
    rst = 1'b0;

    // 25-bit format, odd parity
    load(32'h01A5_C35A, 1'b0, 1'b0);
    check("R2 ready set", {31'h0, data_ready}, 32'h1);
    rd_pulse(1'b0, 1, "R4 R5 first 25");
    @(negedge clk);
    check("R8 first read keeps ready", {31'h0, data_ready}, 32'h1);
    rd_pulse(1'b1, 1, "R5 second 25");
    @(negedge clk);
    check("R8 ready cleared", {31'h0, data_ready}, 32'h0);

    // 32-bit format, even parity, reverse order, repeated reads
    load(32'h7E5A_96F3, 1'b1, 1'b1);
    rd_pulse(1'b1, 2, "R6 R7 second 32");
    @(negedge clk);
    check("R8 ready cleared 32", {31'h0, data_ready}, 32'h0);
    rd_pulse(1'b0, 3, "R6 R4 first 32");
    rd_pulse(1'b1, 1, "R7 reread second");

    // walking ones in both formats
    for (int b = 0; b < 32; b += 3) begin
      load(32'h1 << b, b[0], b[1]);
      rd_pulse(1'b0, 1, "R4 walk first");
      rd_pulse(1'b1, 1, "R5 R6 walk second");
    end

    // mixed pulse: first then second within one pulse clears ready
    load(32'hFFFF_FFFF, 1'b1, 1'b0);
    @(negedge clk);
    rd_en = 1'b1; hw_sel = 1'b0; exp_q.push_back(model_hw(1'b0)); tag_q.push_back("R5 mixed");
    @(negedge clk);
    hw_sel = 1'b1; exp_q.push_back(model_hw(1'b1)); tag_q.push_back("R5 mixed");
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
    check("R8 mixed pulse clears", {31'h0, data_ready}, 32'h0);

    // overwrite of unread word
    load(32'h1234_5678, 1'b0, 1'b1);
    load(32'h0BAD_F00D, 1'b1, 1'b0);
    rd_pulse(1'b1, 1, "R10 newest word");
    rd_pulse(1'b0, 1, "R10 newest word");

    // load coinciding with the clear
    load(32'h2222_2222, 1'b0, 1'b0);
    @(negedge clk);
    rd_en = 1'b1; hw_sel = 1'b1; exp_q.push_back(model_hw(1'b1)); tag_q.push_back("R9 old word");
    @(negedge clk);
    rd_en = 1'b0; ld_strobe = 1'b1; ld_word = 32'h5C3A_81E7; ld_parity = 1'b1; ld_fmt32 = 1'b1;
    @(negedge clk);
    ld_strobe = 1'b0;
    m_word = 32'h5C3A_81E7; m_par = 1'b1; m_fmt = 1'b1;
    check("R9 ready kept", {31'h0, data_ready}, 32'h1);
    rd_pulse(1'b0, 1, "R9 new word first");
    rd_pulse(1'b1, 1, "R9 new word second");

    repeat (3) @(negedge clk);
    check("R7 queue drained", exp_q.size(), 32'h0);
    check("R3 oe low at end", {31'h0, bus_oe}, 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule